// File: doc/BRIEF.md
# Servo Pulse Rate Decimator

This block sits in line between a radio receiver channel and an older motor speed controller that cannot keep up with a fast frame rate. It receives a stream of positive control pulses. These pulses arrive at a steady frame interval and are typically 1 to 2 ms wide. The block forwards only some of them, and each forwarded pulse keeps its full width, so the controller still gets a valid command at a lower repetition rate.

The selection rule is based on time, not on a count. When a forwarded pulse ends, a lockout window of programmable length starts. Any pulse that begins while the window is open is dropped in its entirety. No edge can restart or stretch the window. A window of about one and a half frame intervals keeps every second pulse. A window of about two and a half intervals keeps every third pulse. The window length is given in clock cycles. With a 1 MHz clock, a value of 12000 gives the usual 12 ms lockout for an 8 ms frame.

Top module: `servo_rate_divider`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `pulseOut` is low and no lockout is active. The first complete input pulse after reset is therefore forwarded.
- R2: A forwarded pulse appears on `pulseOut` with exactly the same width in clock cycles as the input pulse. Each output edge follows the clock edge that first samples the matching input edge by two further clock edges.
- R3: Let W be the window length captured when the most recently forwarded pulse ended. An input pulse is forwarded only if the number of clock cycles between that pulse's first high sample and the last forwarded pulse's first low sample is greater than W. A gap of exactly W drops the pulse.
- R4: A dropped pulse neither starts, restarts nor extends the lockout. Only the trailing edge of a forwarded pulse opens a window.
- R5: The pass or drop decision is made at the rising edge of each pulse and holds for the whole pulse. A window that expires partway through a dropped pulse produces no output for any part of that pulse.
- R6: `windowTicks` is captured when a window opens. Changing it while the window is open has no effect on that window.
- R7: With `windowTicks` equal to 0 there is no lockout, and every input pulse is forwarded.
- R8: With a frame interval of P cycles, a window between P and 2P forwards one pulse in two, and a window between 2P and 3P forwards one pulse in three.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| pulseIn | input | 1 | Raw control pulse input, resynchronized inside the block |
| windowTicks | input | WIN_W (24) | Lockout window length in clock cycles |
| pulseOut | output | 1 | Forwarded control pulses, registered |

## Verification
The hardest case to reach is a pulse that starts inside the lockout while the window runs out partway through that pulse. A naive gate would emit the tail of such a pulse. The stimulus uses a short window and places a long pulse so that it rises 20 cycles before expiry and stays high 20 cycles after it, and the reference model expects the output to stay silent for the whole pulse. The exact-boundary gap (W against W+1 cycles) and a window-length change in mid-window are driven as separate short sequences. The reference model is compared with the output on every cycle.

// File: rtl/pdec_pkg.sv
package pdec_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_PASS  = 2'd1,
    ST_BLOCK = 2'd2
  } gateState_t;

  typedef struct packed {
    logic openGate;
    logic closeGate;
    logic armWindow;
  } gateCmd_t;

endpackage

// File: rtl/pdec_datapath.sv
module pdec_datapath
  import pdec_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int WIN_W       = 24
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             pulseIn,
  input  logic [WIN_W-1:0] windowTicks,
  input  gateCmd_t         cmd,
  output logic             syncLevel,
  output logic             riseSeen,
  output logic             fallSeen,
  output logic             winActive,
  output logic             pulseOut
);

  localparam int LAST_STAGE = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] syncChain;
  logic                   lastLevel;
  logic [WIN_W-1:0]       winCount;
  logic                   outReg;

  genvar g;
  generate
    for (g = 0; g < SYNC_STAGES; g++) begin : g_sync
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) syncChain[0] <= 1'b0;
          else     syncChain[0] <= pulseIn;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) syncChain[g] <= 1'b0;
          else     syncChain[g] <= syncChain[g-1];
        end
      end
    end
  endgenerate

  assign syncLevel = syncChain[LAST_STAGE];

  always_ff @(posedge clk) begin
    if (rst) lastLevel <= 1'b0;
    else     lastLevel <= syncLevel;
  end

  assign riseSeen = syncLevel & ~lastLevel;
  assign fallSeen = ~syncLevel & lastLevel;

  // lockout down-counter, loaded once per forwarded pulse
  always_ff @(posedge clk) begin
    if (rst)                  winCount <= '0;
    else if (cmd.armWindow)   winCount <= windowTicks;
    else if (winCount != '0)  winCount <= winCount - 1'b1;
  end

  assign winActive = (winCount != '0);

  always_ff @(posedge clk) begin
    if (rst)                outReg <= 1'b0;
    else if (cmd.openGate)  outReg <= 1'b1;
    else if (cmd.closeGate) outReg <= 1'b0;
  end

  assign pulseOut = outReg;

endmodule

// File: rtl/pdec_control.sv
module pdec_control
  import pdec_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     riseSeen,
  input  logic     fallSeen,
  input  logic     winActive,
  output gateCmd_t cmd
);

  gateState_t state, nextState;

  always_ff @(posedge clk) begin
    if (rst) state <= ST_IDLE;
    else     state <= nextState;
  end

  always_comb begin
    nextState = state;
    cmd       = '0;
    unique case (state)
      ST_IDLE: begin
        if (riseSeen) begin
          if (!winActive) begin
            cmd.openGate = 1'b1;
            nextState    = ST_PASS;
          end else begin
            nextState    = ST_BLOCK;
          end
        end
      end
      ST_PASS: begin
        if (fallSeen) begin
          cmd.closeGate = 1'b1;
          cmd.armWindow = 1'b1;
          nextState     = ST_IDLE;
        end
      end
      ST_BLOCK: begin
        if (fallSeen) nextState = ST_IDLE;
      end
      default: nextState = ST_IDLE;
    endcase
  end

endmodule

// File: rtl/servo_rate_divider.sv
module servo_rate_divider
  import pdec_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int WIN_W       = 24
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             pulseIn,
  input  logic [WIN_W-1:0] windowTicks,
  output logic             pulseOut
);

  gateCmd_t cmd;
  logic     syncLevel;
  logic     riseSeen;
  logic     fallSeen;
  logic     winActive;

  pdec_datapath #(
    .SYNC_STAGES(SYNC_STAGES),
    .WIN_W      (WIN_W)
  ) u_dp (
    .clk        (clk),
    .rst        (rst),
    .pulseIn    (pulseIn),
    .windowTicks(windowTicks),
    .cmd        (cmd),
    .syncLevel  (syncLevel),
    .riseSeen   (riseSeen),
    .fallSeen   (fallSeen),
    .winActive  (winActive),
    .pulseOut   (pulseOut)
  );

  pdec_control u_ctl (
    .clk      (clk),
    .rst      (rst),
    .riseSeen (riseSeen),
    .fallSeen (fallSeen),
    .winActive(winActive),
    .cmd      (cmd)
  );

endmodule

// File: rtl/servo_rate_divider_chk.sv
module servo_rate_divider_chk (
  input logic clk,
  input logic rst,
  input logic pulseOut,
  input logic syncLevel,
  input logic winActive
);

  p_reset_quiet_r1: assert property (@(posedge clk)
    rst |=> (!pulseOut && !winActive));

  p_out_silent_in_window_r3: assert property (@(posedge clk) disable iff (rst)
    winActive |-> !pulseOut);

  p_open_only_when_idle_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(pulseOut) |-> !$past(winActive));

  p_window_from_passed_end_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(winActive) |-> $fell(pulseOut));

  p_hold_while_high_r5: assert property (@(posedge clk) disable iff (rst)
    (pulseOut && syncLevel) |=> pulseOut);

  p_end_follows_input_r2: assert property (@(posedge clk) disable iff (rst)
    $fell(pulseOut) |-> !$past(syncLevel));

endmodule

bind servo_rate_divider servo_rate_divider_chk u_chk (
  .clk      (clk),
  .rst      (rst),
  .pulseOut (pulseOut),
  .syncLevel(syncLevel),
  .winActive(winActive)
);

// File: tb/servo_rate_divider_test.sv
`timescale 1ns/1ps
module servo_rate_divider_test;

  localparam int WIN_W = 24;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             pulseIn = 1'b0;
  logic [WIN_W-1:0] windowTicks = '0;
  logic             pulseOut;

  int total = 0;
  int bad   = 0;

  servo_rate_divider #(.WIN_W(WIN_W)) uut (
    .clk        (clk),
    .rst        (rst),
    .pulseIn    (pulseIn),
    .windowTicks(windowTicks),
    .pulseOut   (pulseOut)
  );

  always #5 clk = ~clk;

  // ---------------- behavioural reference model ----------------
  int cyc = 0;
  int lastFall = -1000000;
  int heldW = 0;
  int riseCyc = 0;
  bit prevIn = 0;
  bit passing = 0;
  bit d0 = 0, d1 = 0, d2 = 0;
  int passWidths[$];

  always @(posedge clk) begin
    cyc = cyc + 1;
    if (rst) begin
      prevIn = 0; passing = 0; lastFall = -1000000; heldW = 0;
      d0 = 0; d1 = 0; d2 = 0;
    end else begin
      if (pulseIn && !prevIn) begin
        riseCyc = cyc;
        passing = ((cyc - lastFall) > heldW);
      end
      if (!pulseIn && prevIn) begin
        if (passing) begin
          lastFall = cyc;
          heldW = int'(windowTicks);
          passWidths.push_back(cyc - riseCyc);
        end
        passing = 0;
      end
      prevIn = pulseIn;
      d2 = d1;
      d1 = d0;
      d0 = pulseIn && passing;
    end
  end

  // ---------------- per-cycle comparison and width monitor ----------------
  int outPulses = 0;
  int hiRun = 0;
  bit lastOut = 0;

  always @(negedge clk) begin
    if (!rst) begin
      total++;
      if (pulseOut !== d2) begin
        bad++;
        $display("FAIL R3 cycle %0d: pulseOut=%0b expected=%0b", cyc, pulseOut, d2);
      end
      if (pulseOut && !lastOut) outPulses++;
      if (pulseOut) hiRun++;
      else if (hiRun > 0) begin
        int want;
        want = (passWidths.size() > 0) ? passWidths.pop_front() : -1;
        total++;
        if (hiRun != want) begin
          bad++;
          $display("FAIL R2 output width=%0d expected=%0d", hiRun, want);
        end
        hiRun = 0;
      end
      lastOut = pulseOut;
    end
  end

  // ---------------- stimulus helpers (called at a negedge) ----------------
  task automatic sendPulse(input int width, input int gap);
    pulseIn = 1'b1;
    repeat (width) @(negedge clk);
    pulseIn = 1'b0;
    repeat (gap) @(negedge clk);
  endtask

  task automatic checkCount(input string tag, input int got, input int exp);
    total++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s pulse count=%0d expected=%0d", tag, got, exp);
    end
  endtask

  task automatic finishRun();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired: got=running expected=finished");
    finishRun();
  end

  initial begin
    int base;
    repeat (4) @(negedge clk);
    // R1: output low during reset
    total++;
    if (pulseOut !== 1'b0) begin
      bad++;
      $display("FAIL R1 pulseOut in reset=%0b expected=0", pulseOut);
    end
    rst = 1'b0;
    @(negedge clk);
    total++;
    if (pulseOut !== 1'b0) begin
      bad++;
      $display("FAIL R1 pulseOut after reset=%0b expected=0", pulseOut);
    end

    // R8: period 80, window 120 -> one in two (R1: first pulse passes)
    windowTicks = 24'd120;
    base = outPulses;
    for (int i = 0; i < 8; i++) sendPulse(10 + i, 70 - i);
    repeat (300) @(negedge clk);
    checkCount("R8 half-rate", outPulses - base, 4);

    // R8/R4: period 80, window 200 -> one in three; retriggering would lose pulses
    windowTicks = 24'd200;
    base = outPulses;
    for (int i = 0; i < 9; i++) sendPulse(12 + (i % 3) * 4, 68 - (i % 3) * 4);
    repeat (300) @(negedge clk);
    checkCount("R4 third-rate", outPulses - base, 3);

    // R5: window 50 expires 20 cycles into a dropped 40-cycle pulse
    windowTicks = 24'd50;
    base = outPulses;
    sendPulse(10, 30);
    sendPulse(40, 60);
    sendPulse(10, 200);
    checkCount("R5 no partial pulse", outPulses - base, 2);

    // R3: gap equal to window is dropped
    windowTicks = 24'd40;
    base = outPulses;
    sendPulse(10, 40);
    sendPulse(10, 200);
    checkCount("R3 gap==W", outPulses - base, 1);

    // R3: gap one above window passes
    base = outPulses;
    sendPulse(10, 41);
    sendPulse(10, 200);
    checkCount("R3 gap==W+1", outPulses - base, 2);

    // R6: window length captured at window start
    windowTicks = 24'd100;
    base = outPulses;
    sendPulse(10, 5);
    windowTicks = 24'd10;
    repeat (55) @(negedge clk);
    sendPulse(10, 200);
    checkCount("R6 latched length", outPulses - base, 1);

    // R7: zero window forwards everything
    windowTicks = 24'd0;
    base = outPulses;
    for (int i = 0; i < 5; i++) sendPulse(10, 20);
    repeat (50) @(negedge clk);
    checkCount("R7 no lockout", outPulses - base, 5);

    finishRun();
  end

endmodule